// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block holds the status byte of a serial NOR flash and decides whether a write-type command may reach the array. A SPI slave front end, running in the same clock domain, delivers the command stream one byte at a time while chip select is low. The block tracks the opcode, up to three address bytes and the first data byte. It acts on write-type commands when chip select returns high. For a status read it supplies the status byte on every byte slot until chip select goes high.

The status byte holds a busy flag, a write-enable latch, a three-bit protect code and a status-protect bit. An accepted write-status, page program, sector erase, block erase or chip erase raises the busy flag and sends a one-cycle start pulse, an operation code and an address to a stubbed array engine. The engine answers with a done pulse. A new status value is committed only at that done pulse. The protect code selects an upper region of the array. A program or erase that would touch that region is refused. The status-protect bit works together with the write-protect pin, and in OTP mode it serves as a one-way lock.

Top module: `spi_flash_status`

## Requirements
- R1: The status byte is {bit7 status-protect, bits 6:5 zero, bits 4:2 protect code, bit1 write-enable latch, bit0 busy}. Reset leaves it 0x00. While opcode 0x05 is the active command and chip select is low, tx_en is 1 and tx_byte carries the status byte. tx_en is 0 at all other times.
- R2: A status read is served at any time, busy or not. Every byte slot of one read shows the status value current in that cycle, so a read that spans the done pulse shows the busy flag drop.
- R3: The busy flag is 1 from the cycle that eng_start is 1 until the cycle after eng_done, and 0 otherwise.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each takes effect when chip select rises.
- R5: While the write-enable latch is 0, opcodes 0x01 (write status), 0x02 (page program), 0x20 (sector erase), 0x D8 (block erase) and 0xC7 (chip erase) are ignored. No start is issued and the status byte does not change.
- R6: The write-enable latch clears when an accepted write-type command completes (eng_done). It also clears when a write-type command is refused by protection.
- R7: While busy, every command except the status read is ignored. This includes 0x06, 0x04 and further write-type commands.
- R8: The protect code and status-protect bit change only through write status (opcode then one data byte, taking bit7 and bits 4:2). They change in the cycle after eng_done, never earlier.
- R9: Let A be ADDR_W. A nonzero protect code c protects addresses at or above 2^A − 2^(A−7+c), so code 7 protects the whole array. The check uses the last address of the unit a command touches: a 256-byte page for 0x02, a 4 KiB sector for 0x20 and a 64 KiB block for 0xD8. If that last address is protected, the command is refused.
- R10: Chip erase starts only when the protect code is 0.
- R11: When the status-protect bit is 1 and wp_n is 0, write status is refused.
- R12: When otp_mode is 1, write status alters only bit7. Once bit7 is 1 in OTP mode, write status, program and erase are all refused.
- R13: A write-type command runs only if it is complete when chip select rises. Write status needs 1 data byte, sector and block erase need 3 address bytes, and page program needs 3 address bytes plus at least 1 data byte. Otherwise it is ignored and the latch is kept. A start gives eng_op 0 = program, 1 = sector erase, 2 = block erase, 3 = chip erase, 4 = write status, and eng_addr = the low ADDR_W bits of the 24-bit address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select from the front end, active low |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received command, address or data byte |
| wp_n | input | 1 | Write-protect pin, active low |
| otp_mode | input | 1 | OTP mode select |
| tx_en | output | 1 | Status read active |
| tx_byte | output | 8 | Status byte for the front end to shift out |
| eng_start | output | 1 | One-cycle start pulse to the array engine |
| eng_op | output | 3 | Operation code given with the start |
| eng_addr | output | ADDR_W | Address given with the start |
| eng_done | input | 1 | One-cycle completion pulse from the engine |

## Verification
The assertions assume three things about the inputs. First, eng_done pulses only while the busy flag is set. Second, rx_valid arrives only while cs_n is low. Third, wp_n and otp_mode are steady from the opcode byte until chip select has risen. The bench drives every input on the falling clock edge and pulses eng_done only after it has seen a start. It changes wp_n and otp_mode only while chip select is high and the previous command has settled. A busy-time done pulse is issued only in the test that holds chip select low across it. In that test no new command is being decoded.

// File: rtl/spi_sr_pkg.sv
// Package: command opcodes and array-engine operation codes shared by the
// status controller modules. Assumes an 8-bit opcode stream.
package spi_sr_pkg;
    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_PP   = 8'h02;
    localparam logic [7:0] OPC_SE   = 8'h20;
    localparam logic [7:0] OPC_BE   = 8'hD8;
    localparam logic [7:0] OPC_CE   = 8'hC7;

    typedef enum logic [2:0] {
        ENG_PROG  = 3'd0,
        ENG_SECT  = 3'd1,
        ENG_BLK   = 3'd2,
        ENG_CHIP  = 3'd3,
        ENG_WRSTA = 3'd4
    } eng_op_e;

    localparam int CNT_W = 3;
endpackage

// File: rtl/sr_cmd_decoder.sv
// Command decoder: captures the opcode, shifts in address bytes, keeps the
// status-relevant fields of the first data byte and counts post-opcode bytes.
// Raises cmd_end for one cycle after chip select rises on a started command.
// Assumes rx_valid only while cs_n is low and ADDR_W <= 24.
module sr_cmd_decoder
    import spi_sr_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        opc,
    output logic [CNT_W-1:0]  nbytes,
    output logic [ADDR_W-1:0] addr,
    output logic              dat_srp,
    output logic [2:0]        dat_bp,
    output logic              cmd_end,
    output logic              rd_active
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic cs_q;
    logic have_op;

    // Capture command bytes and detect the end of a command frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= 1'b1;
            have_op <= 1'b0;
            cmd_end <= 1'b0;
            opc     <= '0;
            nbytes  <= '0;
            addr    <= '0;
            dat_srp <= 1'b0;
            dat_bp  <= '0;
        end else begin
            cs_q    <= cs_n;
            cmd_end <= !cs_q && cs_n && have_op;
            if (cs_n) begin
                have_op <= 1'b0;
            end else if (rx_valid) begin
                if (!have_op) begin
                    have_op <= 1'b1;
                    opc     <= rx_byte;
                    nbytes  <= '0;
                end else begin
                    if (nbytes < CNT_W'(3)) begin
                        addr <= ADDR_W'({addr, rx_byte});
                    end
                    if (nbytes == '0) begin
                        dat_srp <= rx_byte[7];
                        dat_bp  <= rx_byte[4:2];
                    end
                    if (nbytes != CNT_MAX) begin
                        nbytes <= nbytes + 1'b1;
                    end
                end
            end
        end
    end

    // A status read is live while its opcode is held under chip select.
    always_comb rd_active = have_op && !cs_n && (opc == OPC_RDSR);
endmodule

// File: rtl/sr_prot_check.sv
// Protect-region check: works out the last address a command would touch
// and tests it against the upper region chosen by the protect code.
// Assumes BLOCK_LOG2 < ADDR_W and ADDR_W >= 7.
module sr_prot_check
    import spi_sr_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int PAGE_LOG2   = 8,
    parameter int SECTOR_LOG2 = 12,
    parameter int BLOCK_LOG2  = 16
) (
    input  logic [7:0]        opc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bp,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] ALL_M  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] PAGE_M = ALL_M >> (ADDR_W - PAGE_LOG2);
    localparam logic [ADDR_W-1:0] SECT_M = ALL_M >> (ADDR_W - SECTOR_LOG2);
    localparam logic [ADDR_W-1:0] BLK_M  = ALL_M >> (ADDR_W - BLOCK_LOG2);

    logic [ADDR_W-1:0] unit_m;
    logic [ADDR_W-1:0] last_a;
    logic [ADDR_W-1:0] hi_m;

    // Size of the unit touched by the command; chip erase spans everything.
    always_comb begin
        case (opc)
            OPC_PP:  unit_m = PAGE_M;
            OPC_SE:  unit_m = SECT_M;
            OPC_BE:  unit_m = BLK_M;
            default: unit_m = ALL_M;
        endcase
        last_a = addr | unit_m;
    end

    // Mask of the top (7 - code) address bits that select the region.
    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            hi_m[i] = (i >= ADDR_W - (7 - int'(bp)));
        end
    end

    // The unit is refused when its last address sits inside the region.
    always_comb hit = (bp != 3'd0) && ((last_a & hi_m) == hi_m);
endmodule

// File: rtl/sr_status_core.sv
// Status core: holds busy, write-enable latch, protect code and status-protect
// bit; accepts or refuses commands at the end of each frame and drives the
// array-engine handshake. Assumes eng_done pulses only while busy.
module sr_status_core
    import spi_sr_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_end,
    input  logic [7:0]        opc,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dat_srp,
    input  logic [2:0]        dat_bp,
    input  logic              prot_hit,
    input  logic              wp_n,
    input  logic              otp_mode,
    input  logic              eng_done,
    output logic              wip,
    output logic              wel,
    output logic [2:0]        bp,
    output logic              srp,
    output logic              eng_start,
    output eng_op_e           eng_op,
    output logic [ADDR_W-1:0] eng_addr
);
    logic       is_write;
    logic       len_ok;
    logic       refuse;
    logic       pend_sr;
    logic [2:0] new_bp;
    logic       new_srp;
    eng_op_e    op_sel;

    // Classify the command, check its length and map it to an engine code.
    always_comb begin
        is_write = 1'b1;
        len_ok   = 1'b0;
        op_sel   = ENG_CHIP;
        case (opc)
            OPC_WRSR: begin len_ok = (nbytes >= CNT_W'(1)); op_sel = ENG_WRSTA; end
            OPC_PP:   begin len_ok = (nbytes >= CNT_W'(4)); op_sel = ENG_PROG;  end
            OPC_SE:   begin len_ok = (nbytes >= CNT_W'(3)); op_sel = ENG_SECT;  end
            OPC_BE:   begin len_ok = (nbytes >= CNT_W'(3)); op_sel = ENG_BLK;   end
            OPC_CE:   begin len_ok = 1'b1;                  op_sel = ENG_CHIP;  end
            default:  is_write = 1'b0;
        endcase
    end

    // Refusal: hardware lock or OTP lock for status writes, region or OTP lock otherwise.
    always_comb begin
        if (opc == OPC_WRSR) refuse = (srp && !wp_n) || (otp_mode && srp);
        else                 refuse = (otp_mode && srp) || prot_hit;
    end

    // Status state, engine start and completion handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip       <= 1'b0;
            wel       <= 1'b0;
            bp        <= '0;
            srp       <= 1'b0;
            eng_start <= 1'b0;
            eng_op    <= ENG_PROG;
            eng_addr  <= '0;
            pend_sr   <= 1'b0;
            new_bp    <= '0;
            new_srp   <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            if (wip) begin
                if (eng_done) begin
                    wip     <= 1'b0;
                    wel     <= 1'b0;
                    pend_sr <= 1'b0;
                    if (pend_sr) begin
                        bp  <= new_bp;
                        srp <= new_srp;
                    end
                end
            end else if (cmd_end) begin
                if (opc == OPC_WREN) begin
                    wel <= 1'b1;
                end else if (opc == OPC_WRDI) begin
                    wel <= 1'b0;
                end else if (is_write && len_ok && wel) begin
                    if (refuse) begin
                        wel <= 1'b0;
                    end else begin
                        wip       <= 1'b1;
                        eng_start <= 1'b1;
                        eng_op    <= op_sel;
                        eng_addr  <= addr;
                        pend_sr   <= (opc == OPC_WRSR);
                        new_bp    <= otp_mode ? bp : dat_bp;
                        new_srp   <= dat_srp;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_flash_status.sv
// Top: serial flash status register and write-protect controller. Joins the
// command decoder, protect-region check and status core, and presents the
// status byte to the SPI front end during a status read.
module spi_flash_status
    import spi_sr_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int PAGE_LOG2   = 8,
    parameter int SECTOR_LOG2 = 12,
    parameter int BLOCK_LOG2  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              wp_n,
    input  logic              otp_mode,
    output logic              tx_en,
    output logic [7:0]        tx_byte,
    output logic              eng_start,
    output logic [2:0]        eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    input  logic              eng_done
);
    logic [7:0]        d_opc;
    logic [CNT_W-1:0]  d_nbytes;
    logic [ADDR_W-1:0] d_addr;
    logic              d_srp;
    logic [2:0]        d_bp;
    logic              d_end;
    logic              d_rd;
    logic              p_hit;
    logic              st_wip;
    logic              st_wel;
    logic [2:0]        st_bp;
    logic              st_srp;
    eng_op_e           c_op;

    sr_cmd_decoder #(.ADDR_W(ADDR_W)) dec_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .opc(d_opc), .nbytes(d_nbytes), .addr(d_addr),
        .dat_srp(d_srp), .dat_bp(d_bp), .cmd_end(d_end), .rd_active(d_rd)
    );

    sr_prot_check #(
        .ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2),
        .SECTOR_LOG2(SECTOR_LOG2), .BLOCK_LOG2(BLOCK_LOG2)
    ) prot_i (
        .opc(d_opc), .addr(d_addr), .bp(st_bp), .hit(p_hit)
    );

    sr_status_core #(.ADDR_W(ADDR_W)) core_i (
        .clk(clk), .rst_n(rst_n), .cmd_end(d_end), .opc(d_opc),
        .nbytes(d_nbytes), .addr(d_addr), .dat_srp(d_srp), .dat_bp(d_bp),
        .prot_hit(p_hit), .wp_n(wp_n), .otp_mode(otp_mode),
        .eng_done(eng_done), .wip(st_wip), .wel(st_wel), .bp(st_bp),
        .srp(st_srp), .eng_start(eng_start), .eng_op(c_op),
        .eng_addr(eng_addr)
    );

    // Present the live status byte only while a status read is active.
    always_comb begin
        eng_op  = c_op;
        tx_en   = d_rd;
        tx_byte = d_rd ? {st_srp, 2'b00, st_bp, st_wel, st_wip} : 8'h00;
    end
endmodule

// File: rtl/spi_flash_status_chk.sv
// Checker: temporal properties of the status controller, bound to the top.
// Assumes eng_done pulses only while busy.
module spi_flash_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic       eng_start,
    input logic [2:0] eng_op,
    input logic       eng_done,
    input logic       tx_en,
    input logic [7:0] tx_byte,
    input logic       st_wip,
    input logic       st_wel,
    input logic [2:0] st_bp,
    input logic       st_srp
);
    AST_STATUS_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (tx_byte[6:5] == 2'b00 && tx_byte[0] == st_wip && tx_byte[7] == st_srp)); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> st_wip); // R3
    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> st_wel); // R5
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wip && eng_done) |=> (!st_wip && !st_wel)); // R6
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !$past(st_wip)); // R7
    AST_BP_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_bp) |-> $past(st_wip && eng_done)); // R8
    AST_CHIP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_op == 3'd3) |-> (st_bp == 3'd0)); // R10
    AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_op == 3'd4) |-> !(st_srp && !$past(wp_n))); // R11
endmodule

bind spi_flash_status spi_flash_status_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .eng_start(eng_start),
    .eng_op(eng_op), .eng_done(eng_done), .tx_en(tx_en), .tx_byte(tx_byte),
    .st_wip(st_wip), .st_wel(st_wel), .st_bp(st_bp), .st_srp(st_srp)
);

// File: tb/spi_flash_status_tb_top.sv
`timescale 1ns/1ps
module spi_flash_status_tb_top;
    localparam int ADDR_W = 19;
    localparam int NVEC   = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_byte = 8'h00;
    logic              wp_n = 1'b1;
    logic              otp_mode = 1'b0;
    logic              tx_en;
    logic [7:0]        tx_byte;
    logic              eng_start;
    logic [2:0]        eng_op;
    logic [ADDR_W-1:0] eng_addr;
    logic              eng_done = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int starts = 0;
    logic [2:0]        last_op = '0;
    logic [ADDR_W-1:0] last_addr = '0;

    // {protect code, opcode, address, start expected}
    localparam logic [35:0] VEC [NVEC] = '{
        {3'd0, 8'h02, 24'h07FF00, 1'b1},
        {3'd1, 8'h02, 24'h07E000, 1'b0},
        {3'd1, 8'h02, 24'h07DF00, 1'b1},
        {3'd1, 8'h20, 24'h07D000, 1'b1},
        {3'd1, 8'h20, 24'h07E000, 1'b0},
        {3'd1, 8'hD8, 24'h070000, 1'b0},
        {3'd1, 8'hD8, 24'h060000, 1'b1},
        {3'd6, 8'h20, 24'h03F000, 1'b1},
        {3'd6, 8'h20, 24'h040000, 1'b0},
        {3'd7, 8'h02, 24'h000000, 1'b0},
        {3'd0, 8'hC7, 24'h000000, 1'b1},
        {3'd1, 8'hC7, 24'h000000, 1'b0},
        {3'd7, 8'hC7, 24'h000000, 1'b0}
    };

    spi_flash_status #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .wp_n(wp_n), .otp_mode(otp_mode), .tx_en(tx_en),
        .tx_byte(tx_byte), .eng_start(eng_start), .eng_op(eng_op),
        .eng_addr(eng_addr), .eng_done(eng_done)
    );

    always #4 clk = ~clk;

    // Count engine starts and remember the last operation issued.
    always @(posedge clk) begin
        if (rst_n && eng_start) begin
            starts++;
            last_op   = eng_op;
            last_addr = eng_addr;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        tick(3);
    endtask

    task automatic op_only(input logic [7:0] opc);
        cs_n = 1'b0;
        send_byte(opc);
        end_frame();
    endtask

    task automatic op_data(input logic [7:0] opc, input logic [7:0] d);
        cs_n = 1'b0;
        send_byte(opc);
        send_byte(d);
        end_frame();
    endtask

    task automatic op_addr(input logic [7:0] opc, input logic [23:0] a, input int nab, input bit with_data);
        cs_n = 1'b0;
        send_byte(opc);
        if (nab > 0) send_byte(a[23:16]);
        if (nab > 1) send_byte(a[15:8]);
        if (nab > 2) send_byte(a[7:0]);
        if (with_data) send_byte(8'hA5);
        end_frame();
    endtask

    task automatic read_sr(input string req, input logic [7:0] exp);
        cs_n = 1'b0;
        send_byte(8'h05);
        chk(req, {31'd0, tx_en}, 32'd1);
        chk(req, {24'd0, tx_byte}, {24'd0, exp});
        end_frame();
    endtask

    task automatic pulse_done();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        tick(2);
    endtask

    task automatic set_sr(input logic [7:0] d);
        op_only(8'h06);
        op_data(8'h01, d);
        pulse_done();
    endtask

    function automatic logic [2:0] op_code(input logic [7:0] opc);
        case (opc)
            8'h02:   return 3'd0;
            8'h20:   return 3'd1;
            8'hD8:   return 3'd2;
            default: return 3'd3;
        endcase
    endfunction

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int s0;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1: reset state and idle outputs
        chk("R1 tx_en idle", {31'd0, tx_en}, 32'd0);
        chk("R1 no start", {31'd0, eng_start}, 32'd0);
        read_sr("R1 reset status", 8'h00);

        // R5: write-type commands without the latch are ignored
        s0 = starts;
        op_data(8'h01, 8'h1C);
        op_addr(8'h02, 24'h000100, 3, 1'b1);
        op_only(8'hC7);
        chk("R5 no start without latch", starts, s0);
        read_sr("R5 status unchanged", 8'h00);

        // R4: latch set and clear
        op_only(8'h06);
        read_sr("R4 latch set", 8'h02);
        op_only(8'h04);
        read_sr("R4 latch cleared", 8'h00);

        // R9 R10 R6 R13: protection table
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0]  vbp;
            logic [7:0]  vop;
            logic [23:0] va;
            logic        vexp;
            {vbp, vop, va, vexp} = VEC[v];
            set_sr({3'b000, vbp, 2'b00});
            s0 = starts;
            op_only(8'h06);
            if (vop == 8'hC7) op_only(vop);
            else op_addr(vop, va, 3, vop == 8'h02);
            chk("R9 R10 start decision", starts - s0, {31'd0, vexp});
            if (vexp) begin
                chk("R13 engine op", {29'd0, last_op}, {29'd0, op_code(vop)});
                chk("R13 engine addr", {13'd0, last_addr}, {13'd0, va[ADDR_W-1:0]});
                read_sr("R3 busy status", {3'b000, vbp, 2'b11});
                pulse_done();
            end
            read_sr("R6 latch cleared", {3'b000, vbp, 2'b00});
        end
        set_sr(8'h00);
        read_sr("R8 code cleared", 8'h00);

        // R2 R3: continuous read across completion
        op_only(8'h06);
        op_addr(8'h02, 24'h000100, 3, 1'b1);
        cs_n = 1'b0;
        send_byte(8'h05);
        chk("R3 busy during read", {24'd0, tx_byte}, 32'h03);
        tick(1);
        chk("R2 repeated byte", {24'd0, tx_byte}, 32'h03);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        chk("R2 live value after done", {24'd0, tx_byte}, 32'h00);
        end_frame();

        // R7: commands other than the read are ignored while busy
        op_only(8'h06);
        op_addr(8'h20, 24'h001000, 3, 1'b0);
        s0 = starts;
        op_only(8'h04);
        op_data(8'h01, 8'h1C);
        chk("R7 no start while busy", starts, s0);
        read_sr("R7 latch kept while busy", 8'h03);
        pulse_done();
        read_sr("R7 idle after done", 8'h00);

        // R8 R1: status write commits at done; bits 6:5 read zero
        op_only(8'h06);
        s0 = starts;
        op_data(8'h01, 8'hFF);
        chk("R13 status write start", starts - s0, 32'd1);
        chk("R13 status write op", {29'd0, last_op}, 32'd4);
        read_sr("R8 old value while busy", 8'h03);
        pulse_done();
        read_sr("R8 R1 committed value", 8'h9C);

        // R11: hardware lock refuses status write
        wp_n = 1'b0;
        tick(1);
        op_only(8'h06);
        s0 = starts;
        op_data(8'h01, 8'h00);
        chk("R11 no start under lock", starts, s0);
        read_sr("R11 value kept, latch cleared", 8'h9C);
        wp_n = 1'b1;
        tick(1);
        set_sr(8'h00);
        read_sr("R11 write allowed with pin high", 8'h00);

        // R12: OTP mode writes only bit7, then locks
        otp_mode = 1'b1;
        tick(1);
        set_sr(8'h9C);
        read_sr("R12 only bit7 written", 8'h80);
        op_only(8'h06);
        s0 = starts;
        op_addr(8'h02, 24'h000000, 3, 1'b1);
        chk("R12 program refused by lock", starts, s0);
        read_sr("R12 latch cleared on refusal", 8'h80);
        op_only(8'h06);
        op_data(8'h01, 8'h00);
        chk("R12 status write refused by lock", starts, s0);
        read_sr("R12 lock kept", 8'h80);
        otp_mode = 1'b0;
        tick(1);
        set_sr(8'h00);
        read_sr("R12 normal mode write", 8'h00);

        // R13: incomplete command is ignored and keeps the latch
        op_only(8'h06);
        s0 = starts;
        op_addr(8'h20, 24'h001000, 2, 1'b0);
        op_addr(8'h02, 24'h000100, 3, 1'b0);
        chk("R13 short frames ignored", starts, s0);
        read_sr("R13 latch kept", 8'h02);
        op_only(8'h04);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule